// File: doc/BRIEF.md
# Sigma-Delta Fractional Feedback Divider

This block divides a fast input clock by an average ratio of N + F/2^m. N is an integer ratio and F is an m-bit fraction word. Each output period lasts either N or N+1 input clocks. A one-bit first-order delta-sigma modulator picks between the two. Over many periods the share of long periods equals F/2^m. The error left by the one-bit decision is pushed toward high offset frequencies, where a following loop filter removes it.

The block is meant to sit in the feedback path of a frequency synthesizer loop. It gives a one-clock pulse at the end of every output period. It also brings out the modulus-select bit that is in force for the current period.

The modulator steps once per output period. Its integrator is m+2 bits wide and is of the delaying kind: the decision for a period comes from the sum held before that period's update.

Top module: `sdm_frac_divider`

## Requirements
- R1: Every output period lasts exactly N or exactly N+1 input clocks. It lasts N+1 if and only if `mod_sel` is 1 throughout that period, and `mod_sel` changes only at a period boundary.
- R2: With F held constant from reset, periods 1 through 2^m contain exactly F long periods. Period 0 is the first period after reset.
- R3: With F constant from reset, period p (p >= 1) is long exactly when floor(p*F/2^m) exceeds floor((p-1)*F/2^m). Period 0 is always short.
- R4: The integrator word is m+2 bits wide and always stays below 2^(m+1). A sum of 2^m or more selects the long modulus, and 2^m is taken back out at the next update. With F = 2^m - 1 this gives long periods on all but one period in each 2^m.
- R5: A fraction of zero gives only N-clock periods with `mod_sel` low. This holds both from reset and after the fraction is cleared mid-run.
- R6: `ratio_n` and `frac_word` are sampled only in the cycle where `div_pulse` is high. A change that is undone before that cycle has no effect. Values present in that cycle set the ratio of the next period and feed the integrator update.
- R7: Reset is synchronous and active high. While it is held, `div_pulse` and `mod_sel` stay low, with N >= 2. The first period after its release lasts N clocks.
- R8: `div_pulse` is high for exactly one input clock, the last clock of each period.
- R9: Ratio values 0 and 1 are treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_n | input | N_W | Integer ratio N |
| frac_word | input | FRAC_W | Fraction F; the average ratio is N + F/2^FRAC_W |
| div_pulse | output | 1 | One-clock pulse at the last clock of each period |
| mod_sel | output | 1 | 1 when the current period lasts N+1 clocks |

## Verification
Two events can fall in the same cycle: the period boundary, which steps the integrator and loads the next period length, and the loading of a new fraction and ratio. The bench provokes this on purpose. It changes `ratio_n` and `frac_word` exactly in the cycle where `div_pulse` is high. It then checks that the very next period uses the new ratio, and that the long-period sequence restarts with the new fraction as if that boundary were period 0. A second case changes the fraction for a single mid-period cycle and then restores it. That case must leave every period length unchanged.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    // smallest integer ratio the period counter accepts
    localparam int unsigned MIN_RATIO = 2;

    typedef enum logic {
        MOD_SHORT = 1'b0,
        MOD_LONG  = 1'b1
    } mod_e;
endpackage

// File: rtl/sdm_fo_modulator.sv
module sdm_fo_modulator #(
    parameter int unsigned FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              sel,
    output logic              sel_nxt
);
    import sdm_pkg::*;

    localparam int unsigned ACC_W = FRAC_W + 2;
    localparam logic [ACC_W-1:0] FULL = ACC_W'(1) << FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } mod_st_t;

    mod_st_t st_d, st_q;
    logic [ACC_W-1:0] fb;

    // delaying integrator: the decision comes from the stored sum
    always_comb begin
        st_d = st_q;
        fb   = (sel == MOD_LONG) ? FULL : '0;
        if (rst) begin
            st_d.acc = '0;
        end else if (step) begin
            st_d.acc = st_q.acc + {2'b00, frac} - fb;
        end
        sel     = (st_q.acc >= FULL);
        sel_nxt = (st_d.acc >= FULL);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R4: the integrator never reaches twice the full scale
    a_r4_acc_range: assert property (@(posedge clk) disable iff (rst)
        st_q.acc < (FULL << 1));

    // R6: the integrator only moves on a period boundary
    a_r6_acc_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(st_q.acc));
endmodule

// File: rtl/sdm_modulus_counter.sv
module sdm_modulus_counter #(
    parameter int unsigned N_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] ratio,
    input  logic           long_nxt,
    output logic           tc
);
    import sdm_pkg::*;

    localparam int unsigned CNT_W = N_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tgt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] eff;

    always_comb begin
        st_d = st_q;
        eff  = ({1'b0, ratio} < CNT_W'(MIN_RATIO)) ? CNT_W'(MIN_RATIO) : {1'b0, ratio};
        tc   = (st_q.cnt == st_q.tgt);
        if (rst) begin
            st_d.cnt = '0;
            st_d.tgt = eff - CNT_W'(1);
        end else if (tc) begin
            st_d.cnt = '0;
            st_d.tgt = eff + CNT_W'(long_nxt) - CNT_W'(1);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1: the count never passes the loaded terminal value
    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.tgt);

    // R9: every loaded period is at least the minimum ratio long
    a_r9_min_len: assert property (@(posedge clk) disable iff (rst)
        st_q.tgt >= CNT_W'(MIN_RATIO - 1));

    // R8: the terminal pulse never lasts two clocks
    a_r8_pulse_narrow: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);
endmodule

// File: rtl/sdm_frac_divider.sv
module sdm_frac_divider #(
    parameter int unsigned N_W    = 8,
    parameter int unsigned FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_W-1:0]    ratio_n,
    input  logic [FRAC_W-1:0] frac_word,
    output logic              div_pulse,
    output logic              mod_sel
);
    logic tc;
    logic sel_now;
    logic sel_nxt;

    sdm_fo_modulator #(.FRAC_W(FRAC_W)) mod_i (
        .clk     (clk),
        .rst     (rst),
        .step    (tc),
        .frac    (frac_word),
        .sel     (sel_now),
        .sel_nxt (sel_nxt)
    );

    sdm_modulus_counter #(.N_W(N_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .ratio    (ratio_n),
        .long_nxt (sel_nxt),
        .tc       (tc)
    );

    assign div_pulse = tc;
    assign mod_sel   = sel_now;

    // R1: the modulus choice holds for the whole period
    a_r1_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |=> $stable(mod_sel));

    // R5: a zero fraction at a boundary always yields a short next period
    a_r5_zero_frac: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && frac_word == '0) |=> !mod_sel);
endmodule

// File: tb/sdm_frac_divider_tb_top.sv
module sdm_frac_divider_tb_top;
    localparam int unsigned N_W    = 8;
    localparam int unsigned FRAC_W = 8;
    localparam longint      M      = longint'(1) << FRAC_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_W-1:0]    ratio_n = N_W'(5);
    logic [FRAC_W-1:0] frac_word = '0;
    logic              div_pulse;
    logic              mod_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    sdm_frac_divider #(.N_W(N_W), .FRAC_W(FRAC_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ratio_n   (ratio_n),
        .frac_word (frac_word),
        .div_pulse (div_pulse),
        .mod_sel   (mod_sel)
    );

    function automatic int eff_n(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    // expected long flag of period p for a fraction held since period 0
    function automatic bit exp_long(input longint p, input longint f);
        if (p == 0) return 1'b0;
        return ((p * f) / M) != (((p - 1) * f) / M);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int n, input int f);
        @(negedge clk);
        rst = 1'b1;
        ratio_n = N_W'(n);
        frac_word = FRAC_W'(f);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // measures one period starting at its first clock (sampled at negedge)
    task automatic get_period(input int glitch_at, input bit load, input int ln,
                              input int lf, output int len, output bit sel);
        int c;
        logic [FRAC_W-1:0] saved;
        c = 0;
        sel = mod_sel;
        saved = frac_word;
        while (1) begin
            c++;
            if (div_pulse) begin
                if (load) begin
                    ratio_n = N_W'(ln);
                    frac_word = FRAC_W'(lf);
                end
                break;
            end
            if (c > 1000) break;
            if (glitch_at > 0 && c == glitch_at) frac_word = saved ^ FRAC_W'(8'hC8);
            if (glitch_at > 0 && c == glitch_at + 1) frac_word = saved;
            @(negedge clk);
        end
        len = c;
        @(negedge clk);
    endtask

    // checks periods p0 .. p0+num-1 of a sequence whose period 0 saw fraction f
    task automatic run_seq(input int n, input int f, input int p0, input int num,
                           input string tag);
        int len;
        bit sel;
        int longs;
        bit ok_len;
        bit ok_sel;
        longs = 0;
        ok_len = 1'b1;
        ok_sel = 1'b1;
        for (int p = p0; p < p0 + num; p++) begin
            bit eb;
            get_period(0, 1'b0, 0, 0, len, sel);
            eb = exp_long(longint'(p), longint'(f));
            if (len != eff_n(n) + int'(eb)) begin
                if (ok_len) check(1'b0, tag, $sformatf("period %0d length", p),
                                  len, eff_n(n) + int'(eb));
                ok_len = 1'b0;
            end
            if (sel != eb) begin
                if (ok_sel) check(1'b0, "R1", $sformatf("mod_sel in period %0d", p),
                                  sel, eb);
                ok_sel = 1'b0;
            end
            if (len == eff_n(n) + 1) begin
                if (p >= 1 && longint'(p) <= M) longs++;
            end
        end
        if (ok_len) check(1'b1, tag, "period lengths", 0, 0);
        if (ok_sel) check(1'b1, "R1", "mod_sel tracks period length", 0, 0);
        if (p0 <= 1 && longint'(p0 + num - 1) >= M)
            check(longs == f, "R2", $sformatf("long periods over 2^m (F=%0d)", f), longs, f);
    endtask

    initial begin
        int len;
        bit sel;
        int rn;
        int rf;
        void'($urandom(32'd7321));

        // R7: reset state and first period
        do_reset(5, 0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(div_pulse == 1'b0, "R7", "div_pulse during reset", div_pulse, 0);
        check(mod_sel == 1'b0, "R7", "mod_sel during reset", mod_sel, 0);
        rst = 1'b0;
        get_period(0, 1'b0, 0, 0, len, sel);
        check(len == 5, "R7", "first period after reset", len, 5);

        // R5: zero fraction from reset
        do_reset(5, 0);
        run_seq(5, 0, 0, 20, "R5");

        // R3 / R2: directed fractions
        do_reset(3, 1);
        run_seq(3, 1, 0, int'(M) + 1, "R3");
        do_reset(4, 128);
        run_seq(4, 128, 0, int'(M) + 1, "R3");
        // R4: largest fraction, integrator at its widest
        do_reset(2, int'(M) - 1);
        run_seq(2, int'(M) - 1, 0, int'(M) + 1, "R4");

        // R9: ratios below two
        do_reset(0, 0);
        run_seq(0, 0, 0, 6, "R9");
        do_reset(1, 64);
        run_seq(1, 64, 0, 40, "R9");

        // R8: pulse width, observed over a few periods
        do_reset(4, 100);
        for (int k = 0; k < 6; k++) begin
            int hi;
            hi = 0;
            for (int c = 0; c < 6; c++) begin
                if (div_pulse) hi++;
                @(negedge clk);
            end
            check(hi >= 1 && hi <= 2, "R8", "pulses in six clocks", hi, 1);
        end

        // R6: a mid-period fraction change that is undone has no effect
        do_reset(6, 0);
        get_period(0, 1'b0, 0, 0, len, sel);
        get_period(2, 1'b0, 0, 0, len, sel);
        check(len == 6, "R6", "period with glitched fraction", len, 6);
        run_seq(6, 0, 0, 5, "R6");

        // R6 with R5: load in the boundary cycle (coincident with div_pulse)
        do_reset(7, 0);
        get_period(0, 1'b0, 0, 0, len, sel);
        get_period(0, 1'b1, 3, 200, len, sel);
        check(len == 7, "R6", "period ending at the load", len, 7);
        run_seq(3, 200, 1, int'(M), "R6");
        // clear the fraction in a boundary cycle; the integrator drains
        get_period(0, 1'b1, 5, 0, len, sel);
        for (int k = 0; k < 4; k++) begin
            get_period(0, 1'b0, 0, 0, len, sel);
            check(len == 5 && sel == 1'b0, "R5", "zero fraction after clear", len, 5);
        end

        // random ratio and fraction pairs
        for (int t = 0; t < 3; t++) begin
            rn = 2 + int'($urandom_range(0, 10));
            rf = 1 + int'($urandom_range(0, 254));
            do_reset(rn, rf);
            run_seq(rn, rf, 0, int'(M) + 1, "R3");
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule